// File: doc/BRIEF.md
# Multiplexed LCD waveform sequencer

This block produces the drive codes for a four-common, twenty-four-segment multiplexed LCD panel at 1/4 duty. It runs from the system clock with a single-cycle oscillator enable. Every common and segment pin gets a three-bit level code on each cycle. A separate analog stage maps each code onto one of five voltages: ground, one third, one half, two thirds or the full LCD supply. The display image is a 96-bit word in which each segment owns four consecutive bits, one per common.

A frame is split into eight half-phases. In each half-phase one common is selected. The second group of four half-phases repeats the first with the polarity inverted, so every pin averages to zero DC over a frame. A run-time bias bit selects 1/3-bias or 1/2-bias levels. A blanking bit forces every segment to its off waveform while the commons keep scanning. Sleep, or a display-disable flag from reset control, pulls the panel to ground. The first few segment pins can be turned into static output ports. The last two pins can be handed over to a key-scan circuit. The display word and the bias choice are taken only at frame boundaries, so a frame never mixes two images.

Top module: `lcdw_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, every level code, `key_own` and `phase_idx` read 0.
- R2: `phase_idx` steps 0,1,...,7 and then wraps to 0. Each value lasts FRAME_TICKS/8 cycles in which `tick_en` is high (64 by default), so at half rate a half-phase spans twice as many clock cycles.
- R3: Level codes are 0 = ground, 1 = one third, 2 = one half, 3 = two thirds, 4 = full. Common c (bits 3c+2..3c of `com_lvl`) is selected in half-phases c and c+4. When selected it is 4 in half-phases 0-3 and 0 in half-phases 4-7. When not selected it is 1 (half-phases 0-3) or 3 (4-7) at 1/3 bias, and 2 at 1/2 bias.
- R4: Segment pin n (bits 3n+2..3n of `seg_lvl`) uses word bit 4n+c during half-phases c and c+4. An on bit gives 0 in half-phases 0-3 and 4 in half-phases 4-7. An off bit gives 3 then 1 at 1/3 bias, and 2 at 1/2 bias.
- R5: `bias_half` = 0 selects the 1/3-bias levels and 1 selects the 1/2-bias levels.
- R6: With `seg_blank` = 1, every segment-function pin outputs its off waveform and the commons keep their normal sequence.
- R7: While `sleep_req` = 1 or `disp_en` = 0, every common and every segment-function pin reads 0 and `phase_idx` stays 0. When the display resumes, the sequence restarts at half-phase 0.
- R8: `port_sel` = v turns pins 0..v-1 into static ports (v above 4 counts as 4). Port pin k reads 4 when word bit 4k is 1 and 0 otherwise. Ports keep working in sleep and read 0 while `disp_en` = 0.
- R9: `tail_sel` = 00 gives pins 22 and 23 to key scan. 01 gives only pin 23 to key scan. 1x keeps both as segments. A key-scan pin reads 0, and `key_own` bit 0 (pin 22) or bit 1 (pin 23) is 1 exactly when that pin is handed over.
- R10: `disp_word` and `bias_half` are captured only at the end of half-phase 7, or on every cycle while the display is stopped. A change made mid-frame shows first in the next frame's half-phase 0.
- R11: All outputs are registered. `seg_blank`, `sleep_req`, `disp_en`, `port_sel` and `tail_sel` act on the outputs one cycle after they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle strobe from the LCD oscillator divider |
| disp_word | input | 96 | Latched display image, four bits per segment |
| bias_half | input | 1 | 0 selects 1/3 bias, 1 selects 1/2 bias |
| seg_blank | input | 1 | Force all segments to their off waveform |
| sleep_req | input | 1 | Sleep: panel to ground, ports still active |
| disp_en | input | 1 | Display enable from reset control |
| port_sel | input | 3 | Number of leading segment pins used as static ports |
| tail_sel | input | 2 | Function of the last two segment pins |
| com_lvl | output | 12 | Level codes of the four commons, 3 bits each |
| seg_lvl | output | 72 | Level codes of the 24 segment pins, 3 bits each |
| key_own | output | 2 | Last two pins currently given to key scan |
| phase_idx | output | 3 | Half-phase that the level codes belong to |

## Verification
The assertions assume that reset is applied from the first clock. They also assume that `disp_en`, `sleep_req`, `seg_blank`, `port_sel` and `tail_sel` are synchronous levels, so a property sampled at one edge can expect its effect at the next. The common and blanking checks further assume that the level codes are only ever produced by this block's own encoding. The stimulus changes inputs only on falling clock edges. It holds each configuration for at least a full frame, except where it deliberately changes the word and bias mid-frame to exercise the boundary capture. `tick_en` stays either constant or toggles every cycle, so half-phase lengths can be predicted exactly.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  localparam int LVW = 3;

  typedef enum logic [LVW-1:0] {
    LV_GND   = 3'd0,
    LV_THIRD = 3'd1,
    LV_HALF  = 3'd2,
    LV_TWO3  = 3'd3,
    LV_TOP   = 3'd4
  } lvl_e;

endpackage

// File: rtl/lcdw_timebase.sv
module lcdw_timebase #(
  parameter int FRAME_TICKS = 512,
  parameter int N_COM       = 4,
  localparam int HP         = 2 * N_COM,
  localparam int SW         = $clog2(HP),
  localparam int SLOT_TICKS = FRAME_TICKS / HP,
  localparam int TW         = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [SW-1:0] slot_o,
  output logic          load_o
);

  localparam logic [TW-1:0] SUB_LAST  = TW'(SLOT_TICKS - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(HP - 1);

  logic [TW-1:0] sub_q;
  logic [SW-1:0] slot_q;
  logic          sub_end;
  logic          wrap;

  assign sub_end = (sub_q == SUB_LAST);
  assign wrap    = run_i && tick_i && sub_end && (slot_q == SLOT_LAST);
  assign load_o  = !run_i || wrap;
  assign slot_o  = slot_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      sub_q  <= '0;
      slot_q <= '0;
    end else if (tick_i) begin
      if (sub_end) begin
        sub_q  <= '0;
        slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_i && $past(run_i) && !$stable(slot_q)) |->
      (slot_q == (($past(slot_q) == SLOT_LAST) ? '0 : $past(slot_q) + 1'b1))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> ($stable(sub_q) && $stable(slot_q))); // R2

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (slot_q == '0)); // R7

endmodule

// File: rtl/lcdw_frame_latch.sv
module lcdw_frame_latch #(
  parameter int DW = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] word_i,
  input  logic          half_i,
  output logic [DW-1:0] word_o,
  output logic          half_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      half_o <= 1'b0;
    end else if (load_i) begin
      word_o <= word_i;
      half_o <= half_i;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(word_o) && $stable(half_o))); // R10

endmodule

// File: rtl/lcdw_level_gen.sv
module lcdw_level_gen
  import lcdw_pkg::*;
#(
  parameter int N_COM      = 4,
  parameter int N_SEG      = 24,
  parameter int N_PORT_MAX = 4,
  localparam int SW        = $clog2(2 * N_COM),
  localparam int CW        = (N_COM > 1) ? $clog2(N_COM) : 1,
  localparam int PCW       = $clog2(N_PORT_MAX + 1)
) (
  input  logic [SW-1:0]          slot_i,
  input  logic                   active_i,
  input  logic                   en_i,
  input  logic                   half_i,
  input  logic                   blank_i,
  input  logic [N_COM*N_SEG-1:0] word_i,
  input  logic [PCW-1:0]         port_cnt_i,
  input  logic [1:0]             tail_sel_i,
  output logic [N_COM*LVW-1:0]   com_lvl_o,
  output logic [N_SEG*LVW-1:0]   seg_lvl_o,
  output logic [1:0]             ks_own_o
);

  localparam logic [SW-1:0] NC = SW'(N_COM);

  logic          pol;
  logic [CW-1:0] phase;

  assign pol      = (slot_i >= NC);
  assign phase    = pol ? CW'(slot_i - NC) : CW'(slot_i);
  assign ks_own_o = {~tail_sel_i[1], (tail_sel_i == 2'b00)};

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    logic [LVW-1:0] lvl;
    always_comb begin
      if (!active_i)                lvl = LV_GND;
      else if (phase == CW'(c))     lvl = pol ? LV_GND : LV_TOP;
      else if (half_i)              lvl = LV_HALF;
      else                          lvl = pol ? LV_TWO3 : LV_THIRD;
    end
    assign com_lvl_o[c*LVW +: LVW] = lvl;
  end

  for (genvar n = 0; n < N_SEG; n++) begin : g_seg
    logic [N_COM-1:0] grp;
    logic [LVW-1:0]   lvl;
    logic             is_port;
    logic             is_key;

    assign grp = word_i[n*N_COM +: N_COM];

    if (n < N_PORT_MAX) begin : g_port
      assign is_port = (port_cnt_i > PCW'(n));
    end else begin : g_noport
      assign is_port = 1'b0;
    end

    if (n == N_SEG - 2) begin : g_key_a
      assign is_key = (tail_sel_i == 2'b00);
    end else if (n == N_SEG - 1) begin : g_key_b
      assign is_key = ~tail_sel_i[1];
    end else begin : g_nokey
      assign is_key = 1'b0;
    end

    always_comb begin
      if (is_port)                      lvl = (en_i && grp[0]) ? LV_TOP : LV_GND;
      else if (is_key || !active_i)     lvl = LV_GND;
      else if (grp[phase] && !blank_i)  lvl = pol ? LV_TOP : LV_GND;
      else if (half_i)                  lvl = LV_HALF;
      else                              lvl = pol ? LV_THIRD : LV_TWO3;
    end
    assign seg_lvl_o[n*LVW +: LVW] = lvl;
  end

endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
  import lcdw_pkg::*;
#(
  parameter int N_COM       = 4,
  parameter int N_SEG       = 24,
  parameter int FRAME_TICKS = 512,
  parameter int N_PORT_MAX  = 4,
  localparam int DW         = N_COM * N_SEG,
  localparam int SW         = $clog2(2 * N_COM),
  localparam int PCW        = $clog2(N_PORT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic [DW-1:0]        disp_word,
  input  logic                 bias_half,
  input  logic                 seg_blank,
  input  logic                 sleep_req,
  input  logic                 disp_en,
  input  logic [PCW-1:0]       port_sel,
  input  logic [1:0]           tail_sel,
  output logic [N_COM*LVW-1:0] com_lvl,
  output logic [N_SEG*LVW-1:0] seg_lvl,
  output logic [1:0]           key_own,
  output logic [SW-1:0]        phase_idx
);

  localparam logic [PCW-1:0] PMAX = PCW'(N_PORT_MAX);

  logic                 run;
  logic [SW-1:0]        slot;
  logic                 load;
  logic [DW-1:0]        word_s;
  logic                 half_s;
  logic [PCW-1:0]       port_cnt;
  logic [N_COM*LVW-1:0] com_d;
  logic [N_SEG*LVW-1:0] seg_d;
  logic [1:0]           ks_d;

  assign run      = disp_en && !sleep_req;
  assign port_cnt = (port_sel > PMAX) ? PMAX : port_sel;

  lcdw_timebase #(.FRAME_TICKS(FRAME_TICKS), .N_COM(N_COM)) u_tb (
    .clk(clk), .rst(rst), .run_i(run), .tick_i(tick_en),
    .slot_o(slot), .load_o(load)
  );

  lcdw_frame_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .load_i(load), .word_i(disp_word),
    .half_i(bias_half), .word_o(word_s), .half_o(half_s)
  );

  lcdw_level_gen #(.N_COM(N_COM), .N_SEG(N_SEG), .N_PORT_MAX(N_PORT_MAX)) u_gen (
    .slot_i(slot), .active_i(run), .en_i(disp_en), .half_i(half_s),
    .blank_i(seg_blank), .word_i(word_s), .port_cnt_i(port_cnt),
    .tail_sel_i(tail_sel), .com_lvl_o(com_d), .seg_lvl_o(seg_d), .ks_own_o(ks_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl   <= '0;
      seg_lvl   <= '0;
      key_own   <= '0;
      phase_idx <= '0;
    end else begin
      com_lvl   <= com_d;
      seg_lvl   <= seg_d;
      key_own   <= ks_d;
      phase_idx <= slot;
    end
  end

  logic [N_COM-1:0] com_ext;
  logic [N_SEG-1:0] seg_ext;
  for (genvar c = 0; c < N_COM; c++) begin : g_cx
    assign com_ext[c] = (com_lvl[c*LVW +: LVW] == LV_TOP) || (com_lvl[c*LVW +: LVW] == LV_GND);
  end
  for (genvar n = 0; n < N_SEG; n++) begin : g_sx
    assign seg_ext[n] = (seg_lvl[n*LVW +: LVW] == LV_TOP) || (seg_lvl[n*LVW +: LVW] == LV_GND);
  end

  AST_STOP_COMS_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> (com_lvl == '0)); // R7

  AST_ONE_COM_SELECTED: assert property (@(posedge clk) disable iff (rst)
    run |=> ($countones(com_ext) == 1)); // R3

  AST_BLANK_NO_EXTREME: assert property (@(posedge clk) disable iff (rst)
    (run && seg_blank && (port_sel == '0) && tail_sel[1]) |=> (seg_ext == '0)); // R6

  AST_DISABLED_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> ((seg_lvl == '0) && (com_lvl == '0))); // R8

  AST_KEYSCAN_BOTH: assert property (@(posedge clk) disable iff (rst)
    (tail_sel == 2'b00) |=> (key_own == 2'b11)); // R9

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> ##1 (phase_idx == '0)); // R7

endmodule

// File: tb/lcdw_seq_bench.sv
module lcdw_seq_bench;

  typedef struct {
    logic [95:0] word;
    logic        half;
    logic        blank;
    logic        sleep;
    logic        en;
    logic [2:0]  psel;
    logic [1:0]  tsel;
  } cfg_t;

  typedef struct {
    int          h;
    logic [11:0] com;
    logic [71:0] seg;
    logic [1:0]  ks;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic [95:0] disp_word = '0;
  logic        bias_half = 1'b0;
  logic        seg_blank = 1'b0;
  logic        sleep_req = 1'b0;
  logic        disp_en = 1'b0;
  logic [2:0]  port_sel = '0;
  logic [1:0]  tail_sel = 2'b10;
  logic [11:0] com_lvl;
  logic [71:0] seg_lvl;
  logic [1:0]  key_own;
  logic [2:0]  phase_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  lcdw_seq u_lcdw_seq (
    .clk(clk), .rst(rst), .tick_en(tick_en), .disp_word(disp_word),
    .bias_half(bias_half), .seg_blank(seg_blank), .sleep_req(sleep_req),
    .disp_en(disp_en), .port_sel(port_sel), .tail_sel(tail_sel),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .key_own(key_own), .phase_idx(phase_idx)
  );

  // Reference from the requirements: codes 0 gnd, 1 third, 2 half, 3 two-thirds, 4 full
  function automatic exp_t model(cfg_t c, int h);
    exp_t e;
    bit act = c.en && !c.sleep;
    bit pol = (h >= 4);
    int sel = h % 4;
    int np = (c.psel > 4) ? 4 : int'(c.psel);
    e.h = h;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] v;
      if (!act) v = 3'd0;
      else if (k == sel) v = pol ? 3'd0 : 3'd4;
      else if (c.half) v = 3'd2;
      else v = pol ? 3'd3 : 3'd1;
      e.com[k*3 +: 3] = v;
    end
    e.ks = {~c.tsel[1], (c.tsel == 2'b00)};
    for (int n = 0; n < 24; n++) begin
      logic [2:0] v;
      bit key = (n == 22 && c.tsel == 2'b00) || (n == 23 && !c.tsel[1]);
      if (n < np) v = (c.en && c.word[4*n]) ? 3'd4 : 3'd0;
      else if (key || !act) v = 3'd0;
      else if (c.word[4*n + sel] && !c.blank) v = pol ? 3'd4 : 3'd0;
      else if (c.half) v = 3'd2;
      else v = pol ? 3'd1 : 3'd3;
      e.seg[n*3 +: 3] = v;
    end
    return e;
  endfunction

  task automatic note(bit ok, string msg, string act_s, string exp_s);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", msg, act_s, exp_s);
    end
  endtask

  task automatic compare(exp_t e);
    note(com_lvl === e.com && seg_lvl === e.seg && key_own === e.ks && phase_idx === 3'(e.h),
         $sformatf("%s half-phase %0d", e.tag, e.h),
         $sformatf("com=%h seg=%h ks=%b ph=%0d", com_lvl, seg_lvl, key_own, phase_idx),
         $sformatf("com=%h seg=%h ks=%b ph=%0d", e.com, e.seg, e.ks, e.h));
  endtask

  // Monitor: pops expected items and compares once the design shows that half-phase
  initial begin
    forever begin
      wait (q.size() > 0);
      while (phase_idx !== 3'(q[0].h)) @(negedge clk);
      compare(q[0]);
      void'(q.pop_front());
      @(negedge clk);
    end
  end

  task automatic drive(cfg_t c);
    @(negedge clk);
    disp_word = c.word; bias_half = c.half; seg_blank = c.blank;
    sleep_req = c.sleep; disp_en = c.en; port_sel = c.psel; tail_sel = c.tsel;
  endtask

  task automatic wait_boundary();
    logic [2:0] prev = phase_idx;
    forever begin
      @(negedge clk);
      if (prev == 3'd7 && phase_idx == 3'd0) break;
      prev = phase_idx;
    end
  endtask

  task automatic run_frame(cfg_t c, string tag);
    drive(c);
    wait_boundary();
    for (int h = 0; h < 8; h++) begin
      exp_t e = model(c, h);
      e.tag = tag;
      q.push_back(e);
    end
    wait (q.size() == 0);
  endtask

  task automatic run_stopped(cfg_t c, string tag);
    exp_t e;
    drive(c);
    repeat (3) @(negedge clk);
    e = model(c, 0);
    e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic measure(bit half_rate, int expect_len);
    logic [2:0] prev;
    int len = 0;
    int seen = 0;
    prev = phase_idx;
    while (seen < 2) begin
      @(negedge clk);
      if (half_rate) tick_en = ~tick_en;
      len++;
      if (phase_idx != prev) begin
        if (seen == 1)
          note(len == expect_len && phase_idx == prev + 3'd1,
               $sformatf("R2 half-phase length (half_rate=%0d)", half_rate),
               $sformatf("len=%0d next=%0d", len, phase_idx),
               $sformatf("len=%0d next=%0d", expect_len, prev + 3'd1));
        seen++;
        len = 0;
        prev = phase_idx;
      end
    end
    tick_en = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_t a, b, c;
    exp_t e;

    // R1: reset state
    repeat (3) @(negedge clk);
    note(com_lvl === '0 && seg_lvl === '0 && key_own === '0 && phase_idx === '0,
         "R1 outputs during reset", $sformatf("%h %h %b %0d", com_lvl, seg_lvl, key_own, phase_idx), "all zero");
    rst = 1'b0;
    @(negedge clk);
    note(com_lvl === '0 && seg_lvl === '0 && key_own === '0 && phase_idx === '0,
         "R1 outputs after release", $sformatf("%h %h %b %0d", com_lvl, seg_lvl, key_own, phase_idx), "all zero");

    a = '{word: 96'h0123_4567_89AB_CDEF_F0E1_D2C3, half: 1'b0, blank: 1'b0,
          sleep: 1'b0, en: 1'b1, psel: 3'd0, tsel: 2'b10};
    run_frame(a, "R3/R4/R5 third bias");

    b = a; b.half = 1'b1; b.word = 96'hA5A5_5A5A_3C3C_C3C3_0F0F_F00F;
    run_frame(b, "R3/R4/R5 half bias");

    c = a; c.blank = 1'b1;
    run_frame(c, "R6 blank");

    c = a; c.psel = 3'd3; c.tsel = 2'b00;
    run_frame(c, "R8/R9 three ports, both key");

    c = b; c.psel = 3'd7; c.tsel = 2'b01;
    run_frame(c, "R8/R9 saturated ports, one key");

    c = a; c.sleep = 1'b1; c.psel = 3'd2;
    run_stopped(c, "R7/R8 sleep ports live");

    c = a; c.en = 1'b0; c.psel = 3'd4; c.tsel = 2'b00;
    run_stopped(c, "R7/R8 disabled");

    run_frame(a, "R7 resume");

    // R11: blanking takes effect one cycle after the input changes
    @(negedge clk);
    seg_blank = 1'b1;
    @(negedge clk);
    c = a; c.blank = 1'b1;
    e = model(c, int'(phase_idx));
    note(seg_lvl === e.seg, "R11 blank one cycle later", $sformatf("%h", seg_lvl), $sformatf("%h", e.seg));
    seg_blank = 1'b0;

    // R10: mid-frame word and bias change is deferred to the next frame
    wait_boundary();
    disp_word = b.word; bias_half = 1'b1;
    while (phase_idx != 3'd2) @(negedge clk);
    e = model(a, 2);
    note(seg_lvl === e.seg && com_lvl === e.com, "R10 old image kept mid-frame",
         $sformatf("%h %h", com_lvl, seg_lvl), $sformatf("%h %h", e.com, e.seg));
    wait_boundary();
    e = model(b, 0);
    note(seg_lvl === e.seg && com_lvl === e.com, "R10 new image at next frame",
         $sformatf("%h %h", com_lvl, seg_lvl), $sformatf("%h %h", e.com, e.seg));

    // R2: half-phase length at full and half tick rate
    measure(1'b0, 64);
    measure(1'b1, 128);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule